// File: doc/BRIEF.md
# Inter-Access Idle Cycle Inserter

This block sits in front of an external bus sequencer and decides when the next queued access may start. It remembers the previous external access: whether it was a read or a write, which chip-select space it used, and whether it was a DMA single-address transfer in which an external device drove the data bus. When the sequencer reports that chip select has negated, the block counts bus clocks. A pending request is granted only after the idle gap chosen for the pair (previous access, new access) has gone by.

The gap comes from 3-bit codes. Five access-pair codes are kept per chip-select space, and the space of the previous access selects which set applies. A global DMA code and a global DMA mode bit add a second condition. A per-space flag for a multiplexed write-enable pin adds a fixed minimum gap. When several conditions apply at once, the largest gap is used.

The request side is a valid/ready stream. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` may be high while `req_valid` is low. While `req_valid` is high and `req_ready` is low, the requester must hold every `req_*` field stable. The grant decision depends on those fields, so the block applies back-pressure to a request until its gap has gone by.

Top module: `idle_gap_inserter`

## Requirements
- R1: After reset no previous access is recorded, so the first request sees `req_ready` high in the same cycle its `req_valid` rises.
- R2: From the edge that accepts a request through the cycle in which `cs_negate` is high, `req_ready` stays low.
- R3: When the previous access was a write, the gap is the decoded value of the previous space's `cfg_wr_any` field, whatever the direction of the new access.
- R4: When a read is followed by a write, the gap uses the previous space's `cfg_rw_diff` field if `req_cs` differs from the previous space, and its `cfg_rw_same` field if they match.
- R5: When a read is followed by a read, the gap uses the previous space's `cfg_rr_diff` field for a different space and its `cfg_rr_same` field for the same space.
- R6: Space s owns bits [3s+2:3s] of each per-space field. The codes 0..7 decode to 0, 1, 2, 4, 6, 8, 10 and 12 idle cycles.
- R7: With `cfg_dma_any`=0, the decoded `cfg_dma_code` applies after a previous access flagged `req_dma_sa` only when the new request has `req_data_other`=1.
- R8: With `cfg_dma_any`=1, the DMA gap applies after a flagged previous access whatever the new request is.
- R9: When the DMA gap and the access-pair gap both apply, the larger of the two is used.
- R10: If `cfg_mux_we` is set for the previous access's space, the gap is at least WE_FLOOR (default 3) cycles.
- R11: When the gap is N, `req_ready` is low for exactly N cycles after the `cs_negate` cycle and rises in the next one. A gap of 0 grants in the cycle right after negation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request pending |
| req_ready | output | 1 | Grant; the request transfers when this and valid are both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | $clog2(NCS) | Target chip-select space |
| req_dma_sa | input | 1 | Request is a DMA single-address transfer with an external device driving data |
| req_data_other | input | 1 | Data for this request is driven by a device other than the previous data driver |
| cs_negate | input | 1 | Pulse from the sequencer in the cycle chip select negates |
| cfg_wr_any | input | 3*NCS | Per-space code for a write followed by any access |
| cfg_rw_diff | input | 3*NCS | Per-space code for a read then a write, different space |
| cfg_rw_same | input | 3*NCS | Per-space code for a read then a write, same space |
| cfg_rr_diff | input | 3*NCS | Per-space code for a read then a read, different space |
| cfg_rr_same | input | 3*NCS | Per-space code for a read then a read, same space |
| cfg_dma_code | input | 3 | Global DMA idle code |
| cfg_dma_any | input | 1 | DMA gap applies to any following access |
| cfg_mux_we | input | NCS | Per-space multiplexed write-enable floor enable |

## Verification
Three gap sources can be active in the same cycle: the access-pair code, the DMA code and the write-enable floor. The bench sets these up with a DMA-flagged read followed by a read to the same space. It runs the case once with the pair code below the DMA code and once with the pair code above it. It runs a separate case where the floor is larger than a small pair code. Each case is judged by counting the cycles in which `req_ready` stays low after negation and comparing that count with the maximum of the sources the bench itself expects to be active.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;
  localparam int CODE_W = 3;
  localparam int GAP_W  = 4;

  typedef enum logic [2:0] {
    PC_NONE,
    PC_WR_ANY,
    PC_RW_DIFF,
    PC_RW_SAME,
    PC_RR_DIFF,
    PC_RR_SAME
  } pair_class_e;

  // code -> idle cycles: 0,1,2 map to themselves, above that 2*(code-1)
  function automatic logic [GAP_W-1:0] gap_decode(input logic [CODE_W-1:0] c);
    logic [GAP_W-1:0] t;
    t = GAP_W'(c) - GAP_W'(1);
    return (c < CODE_W'(2)) ? GAP_W'(c) : (t << 1);
  endfunction

  function automatic logic [GAP_W-1:0] gap_max(input logic [GAP_W-1:0] a,
                                               input logic [GAP_W-1:0] b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/idle_pair_class.sv
module idle_pair_class
  import idle_gap_pkg::*;
#(
  parameter int CSW = 2
) (
  input  logic           prev_valid,
  input  logic           prev_write,
  input  logic [CSW-1:0] prev_cs,
  input  logic           req_write,
  input  logic [CSW-1:0] req_cs,
  output pair_class_e    pclass
);
  logic same_space;
  assign same_space = (prev_cs == req_cs);

  always_comb begin
    if (!prev_valid)     pclass = PC_NONE;
    else if (prev_write) pclass = PC_WR_ANY;
    else if (req_write)  pclass = same_space ? PC_RW_SAME : PC_RW_DIFF;
    else                 pclass = same_space ? PC_RR_SAME : PC_RR_DIFF;
  end
endmodule

// File: rtl/idle_need_calc.sv
module idle_need_calc
  import idle_gap_pkg::*;
#(
  parameter int NCS      = 4,
  parameter int CSW      = 2,
  parameter int WE_FLOOR = 3
) (
  input  pair_class_e            pclass,
  input  logic                   prev_valid,
  input  logic                   prev_dma,
  input  logic [CSW-1:0]         prev_cs,
  input  logic                   req_data_other,
  input  logic [NCS*CODE_W-1:0]  cfg_wr_any,
  input  logic [NCS*CODE_W-1:0]  cfg_rw_diff,
  input  logic [NCS*CODE_W-1:0]  cfg_rw_same,
  input  logic [NCS*CODE_W-1:0]  cfg_rr_diff,
  input  logic [NCS*CODE_W-1:0]  cfg_rr_same,
  input  logic [CODE_W-1:0]      cfg_dma_code,
  input  logic                   cfg_dma_any,
  input  logic [NCS-1:0]         cfg_mux_we,
  output logic [GAP_W-1:0]       need
);
  localparam logic [GAP_W-1:0] FLOOR_V = GAP_W'(WE_FLOOR);

  logic [CODE_W-1:0] pair_code;
  logic [GAP_W-1:0]  pair_gap;
  logic [GAP_W-1:0]  dma_gap;
  logic [GAP_W-1:0]  floor_gap;
  int                base;

  always_comb begin
    base = int'(prev_cs) * CODE_W;
    unique case (pclass)
      PC_WR_ANY:  pair_code = cfg_wr_any[base +: CODE_W];
      PC_RW_DIFF: pair_code = cfg_rw_diff[base +: CODE_W];
      PC_RW_SAME: pair_code = cfg_rw_same[base +: CODE_W];
      PC_RR_DIFF: pair_code = cfg_rr_diff[base +: CODE_W];
      PC_RR_SAME: pair_code = cfg_rr_same[base +: CODE_W];
      default:    pair_code = '0;
    endcase
    pair_gap = gap_decode(pair_code);
    dma_gap  = (prev_valid && prev_dma && (cfg_dma_any || req_data_other))
             ? gap_decode(cfg_dma_code) : '0;
  end

  generate
    if (WE_FLOOR > 0) begin : g_floor
      assign floor_gap = (prev_valid && cfg_mux_we[prev_cs]) ? FLOOR_V : '0;
    end else begin : g_no_floor
      assign floor_gap = '0;
    end
  endgenerate

  assign need = gap_max(gap_max(pair_gap, dma_gap), floor_gap);
endmodule

// File: rtl/idle_gap_timer.sv
module idle_gap_timer
  import idle_gap_pkg::*;
#(
  parameter int CSW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [CSW-1:0]   req_cs,
  input  logic             req_dma_sa,
  input  logic             cs_negate,
  input  logic [GAP_W-1:0] need,
  output logic             ready,
  output logic             prev_valid,
  output logic             prev_write,
  output logic [CSW-1:0]   prev_cs,
  output logic             prev_dma
);
  logic             busy;
  logic [GAP_W-1:0] elapsed;
  logic             accept;

  assign ready  = !busy && (elapsed >= need);
  assign accept = req_valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      elapsed    <= '1;
      prev_valid <= 1'b0;
      prev_write <= 1'b0;
      prev_cs    <= '0;
      prev_dma   <= 1'b0;
    end else if (accept) begin
      busy       <= 1'b1;
      prev_valid <= 1'b1;
      prev_write <= req_write;
      prev_cs    <= req_cs;
      prev_dma   <= req_dma_sa;
    end else if (busy && cs_negate) begin
      busy    <= 1'b0;
      elapsed <= '0;
    end else if (!busy && (elapsed != '1)) begin
      elapsed <= elapsed + GAP_W'(1);
    end
  end
endmodule

// File: rtl/idle_gap_inserter.sv
module idle_gap_inserter
  import idle_gap_pkg::*;
#(
  parameter int NCS      = 4,
  parameter int WE_FLOOR = 3,
  localparam int CSW     = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [CSW-1:0]        req_cs,
  input  logic                  req_dma_sa,
  input  logic                  req_data_other,
  input  logic                  cs_negate,
  input  logic [NCS*CODE_W-1:0] cfg_wr_any,
  input  logic [NCS*CODE_W-1:0] cfg_rw_diff,
  input  logic [NCS*CODE_W-1:0] cfg_rw_same,
  input  logic [NCS*CODE_W-1:0] cfg_rr_diff,
  input  logic [NCS*CODE_W-1:0] cfg_rr_same,
  input  logic [CODE_W-1:0]     cfg_dma_code,
  input  logic                  cfg_dma_any,
  input  logic [NCS-1:0]        cfg_mux_we
);
  logic             prev_valid, prev_write, prev_dma;
  logic [CSW-1:0]   prev_cs;
  pair_class_e      pclass;
  logic [GAP_W-1:0] need;

  idle_pair_class #(.CSW(CSW)) u_class (
    .prev_valid (prev_valid),
    .prev_write (prev_write),
    .prev_cs    (prev_cs),
    .req_write  (req_write),
    .req_cs     (req_cs),
    .pclass     (pclass)
  );

  idle_need_calc #(.NCS(NCS), .CSW(CSW), .WE_FLOOR(WE_FLOOR)) u_need (
    .pclass         (pclass),
    .prev_valid     (prev_valid),
    .prev_dma       (prev_dma),
    .prev_cs        (prev_cs),
    .req_data_other (req_data_other),
    .cfg_wr_any     (cfg_wr_any),
    .cfg_rw_diff    (cfg_rw_diff),
    .cfg_rw_same    (cfg_rw_same),
    .cfg_rr_diff    (cfg_rr_diff),
    .cfg_rr_same    (cfg_rr_same),
    .cfg_dma_code   (cfg_dma_code),
    .cfg_dma_any    (cfg_dma_any),
    .cfg_mux_we     (cfg_mux_we),
    .need           (need)
  );

  idle_gap_timer #(.CSW(CSW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_cs     (req_cs),
    .req_dma_sa (req_dma_sa),
    .cs_negate  (cs_negate),
    .need       (need),
    .ready      (req_ready),
    .prev_valid (prev_valid),
    .prev_write (prev_write),
    .prev_cs    (prev_cs),
    .prev_dma   (prev_dma)
  );
endmodule

// File: rtl/idle_gap_checker.sv
module idle_gap_checker
  import idle_gap_pkg::*;
#(
  parameter int NCS      = 4,
  parameter int WE_FLOOR = 3,
  localparam int CSW     = (NCS > 1) ? $clog2(NCS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CSW-1:0]    req_cs,
  input logic              req_dma_sa,
  input logic              cs_negate,
  input logic [CODE_W-1:0] cfg_dma_code,
  input logic              cfg_dma_any,
  input logic [NCS-1:0]    cfg_mux_we
);
  logic             acc, c_busy, seen_acc, last_dma;
  logic [CSW-1:0]   last_cs;
  logic [GAP_W-1:0] since;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_busy <= 1'b0; seen_acc <= 1'b0; last_dma <= 1'b0;
      last_cs <= '0; since <= '1;
    end else begin
      if (acc) begin
        c_busy <= 1'b1; seen_acc <= 1'b1;
        last_dma <= req_dma_sa; last_cs <= req_cs;
      end else if (c_busy && cs_negate) begin
        c_busy <= 1'b0;
        since  <= '0;
      end else if (since != '1) begin
        since <= since + GAP_W'(1);
      end
    end
  end

  a_r1_first_free: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_acc && req_valid) |-> req_ready);

  a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    c_busy |-> !req_ready);

  a_r8_dma_any_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && seen_acc && last_dma && cfg_dma_any) |-> (since >= gap_decode(cfg_dma_code)));

  a_r10_we_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && seen_acc && cfg_mux_we[last_cs]) |-> (since >= GAP_W'(WE_FLOOR)));
endmodule

bind idle_gap_inserter idle_gap_checker #(.NCS(NCS), .WE_FLOOR(WE_FLOOR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_cs       (req_cs),
  .req_dma_sa   (req_dma_sa),
  .cs_negate    (cs_negate),
  .cfg_dma_code (cfg_dma_code),
  .cfg_dma_any  (cfg_dma_any),
  .cfg_mux_we   (cfg_mux_we)
);

// File: tb/idle_gap_inserter_bench.sv
module idle_gap_inserter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;
  localparam int CSW = 2;
  localparam int MAP [8] = '{0, 1, 2, 4, 6, 8, 10, 12};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_dma_sa = 1'b0, req_data_other = 1'b0;
  logic [CSW-1:0] req_cs = '0;
  logic cs_negate = 1'b0;
  logic req_ready;
  logic [NCS*3-1:0] cfg_wr_any, cfg_rw_diff, cfg_rw_same, cfg_rr_diff, cfg_rr_same;
  logic [2:0] cfg_dma_code = 3'd4;
  logic cfg_dma_any = 1'b0;
  logic [NCS-1:0] cfg_mux_we = '0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_gap_inserter #(.NCS(NCS), .WE_FLOOR(3)) u_idle_gap_inserter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cs(req_cs), .req_dma_sa(req_dma_sa),
    .req_data_other(req_data_other), .cs_negate(cs_negate),
    .cfg_wr_any(cfg_wr_any), .cfg_rw_diff(cfg_rw_diff), .cfg_rw_same(cfg_rw_same),
    .cfg_rr_diff(cfg_rr_diff), .cfg_rr_same(cfg_rr_same),
    .cfg_dma_code(cfg_dma_code), .cfg_dma_any(cfg_dma_any), .cfg_mux_we(cfg_mux_we)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // access A, then B; count ready-low cycles after A's negation
  task automatic gap_case(input logic aw, input int acs, input logic adma,
                          input logic bw, input int bcs, input logic bother,
                          input int exp, input string tag);
    int n;
    @(negedge clk);
    req_write = aw; req_cs = CSW'(acs); req_dma_sa = adma; req_data_other = 1'b0;
    req_valid = 1'b1;
    n = 0; #1;
    while (!req_ready && n < 100) begin @(negedge clk); #1; n++; end
    @(negedge clk);
    req_write = bw; req_cs = CSW'(bcs); req_dma_sa = 1'b0; req_data_other = bother;
    #1 chk(req_ready == 1'b0, {"R2 busy ", tag}, int'(req_ready), 0);
    @(negedge clk); cs_negate = 1'b1;
    #1 chk(req_ready == 1'b0, {"R2 negate cycle ", tag}, int'(req_ready), 0);
    @(negedge clk); cs_negate = 1'b0;
    n = 0; #1;
    while (!req_ready && n < 40) begin n++; @(negedge clk); #1; end
    chk(n == exp, tag, n, exp);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk); cs_negate = 1'b1;
    @(negedge clk); cs_negate = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_cs = '0;
    #1 chk(req_ready == 1'b1, "R1 first request granted at once", int'(req_ready), 1);
    @(negedge clk); req_valid = 1'b0;
    #1 chk(req_ready == 1'b0, "R2 busy after first accept", int'(req_ready), 0);
    @(negedge clk); cs_negate = 1'b1;
    @(negedge clk); cs_negate = 1'b0;
  endtask

  task automatic t_pairs;
    gap_case(1, 0, 0, 1, 0, 0, MAP[3], "R3 write-write same cs0");
    gap_case(1, 1, 0, 0, 2, 0, MAP[2], "R3 write-read diff cs1");
    gap_case(0, 0, 0, 1, 1, 0, MAP[5], "R4 read-write diff cs0");
    gap_case(0, 2, 0, 1, 2, 0, MAP[6], "R4 read-write same cs2");
    gap_case(0, 3, 0, 0, 0, 0, MAP[5], "R5 read-read diff cs3");
    gap_case(0, 1, 0, 0, 1, 0, MAP[7], "R5 read-read same cs1");
  endtask

  task automatic t_codes;
    for (int c = 0; c < 8; c++) begin
      cfg_rr_same[0 +: 3] = 3'(c);
      gap_case(0, 0, 0, 0, 0, 0, MAP[c], $sformatf("R6 code %0d", c));
    end
    cfg_rr_same[0 +: 3] = 3'd0;
    gap_case(0, 0, 0, 0, 0, 0, 0, "R11 zero gap grants next cycle");
  endtask

  task automatic t_dma;
    cfg_rr_same[0 +: 3] = 3'd1;
    cfg_dma_any = 1'b0;
    gap_case(0, 0, 1, 0, 0, 0, 1, "R7 dma mode0 same driver");
    gap_case(0, 0, 1, 0, 0, 1, 6, "R7 dma mode0 other driver");
    cfg_dma_any = 1'b1;
    gap_case(0, 0, 1, 0, 0, 0, 6, "R8 dma mode1 any access");
    cfg_rr_same[0 +: 3] = 3'd7;
    gap_case(0, 0, 1, 0, 0, 0, 12, "R9 larger pair gap wins");
    cfg_rr_same[0 +: 3] = 3'd1;
    gap_case(0, 0, 0, 0, 0, 1, 1, "R7 no dma flag no dma gap");
    cfg_dma_any = 1'b0;
  endtask

  task automatic t_floor;
    cfg_mux_we[3] = 1'b1;
    gap_case(0, 3, 0, 1, 3, 0, 3, "R10 floor over read-write same");
    gap_case(1, 3, 0, 1, 3, 0, 3, "R10 floor over write-any");
    gap_case(0, 3, 0, 0, 0, 0, 8, "R10 pair gap above floor");
    cfg_mux_we[3] = 1'b0;
  endtask

  initial begin
    cfg_wr_any  = {3'd1, 3'd4, 3'd2, 3'd3};
    cfg_rw_diff = {3'd1, 3'd1, 3'd1, 3'd5};
    cfg_rw_same = {3'd2, 3'd6, 3'd2, 3'd2};
    cfg_rr_diff = {3'd5, 3'd2, 3'd2, 3'd2};
    cfg_rr_same = {3'd0, 3'd0, 3'd7, 3'd0};
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_pairs();
    t_codes();
    t_dma();
    t_floor();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule